// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits between the byte output of a framing receiver and the write port of a receive FIFO. It counts the bytes of each frame and passes them on to the FIFO until a maximum length, programmed by software, is reached. Once a frame grows past that maximum, the block stops writing to the FIFO. It stays silent for the rest of that frame, and a sticky status bit records the overrun. Normal writing resumes with the next start flag.

Software loads the 13-bit maximum through two byte-wide write strobes, one for the low byte and one for the high bits. It reads back the number of bytes received in the current or most recent frame. The status bit is cleared either by a read strobe or by a write that has bit 0 set. A maximum of zero turns the limit off.

Top module: `rx_len_guard`

## Requirements
- R1: After reset, the limit is 0, the frame count is 0, the exceeded bit is 0 and no FIFO write is issued.
- R2: A pulse on cfg_wr_lo loads cfg_wdata[7:0] into limit bits 7:0. A pulse on cfg_wr_hi loads cfg_wdata[4:0] into limit bits 12:8. The stored value appears on limit_val.
- R3: A start flag (frame_sof) clears the frame count. A byte strobed in the same cycle as the start flag counts as the first byte of the new frame.
- R4: Each byte received inside a frame increments the frame count by one. The count saturates at 8191 and does not wrap.
- R5: With a nonzero limit L, the first L bytes of a frame are written to the FIFO one cycle after they arrive, with unchanged data. Byte L+1 and every later byte are dropped until the next start flag.
- R6: The exceeded bit becomes 1 in the cycle after the first dropped byte and stays 1 until cleared.
- R7: The exceeded bit is cleared by a stat_rd pulse, or by a stat_clr_wr pulse with cfg_wdata[0]=1. A clear write with cfg_wdata[0]=0 has no effect. A new overrun in the same cycle as a clear wins, so the bit stays 1.
- R8: A limit of 0 enforces no limit. Every in-frame byte is written, and the exceeded bit is never set.
- R9: Bytes that arrive outside a frame are neither counted nor written. This covers bytes after reset before the first start flag, and bytes after an end-of-frame before the next start flag.
- R10: A byte strobed in the same cycle as frame_eof belongs to the frame that is ending. It is counted and, if within the limit, written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_lo | input | 1 | Load limit low byte from cfg_wdata |
| cfg_wr_hi | input | 1 | Load limit high bits from cfg_wdata[4:0] |
| stat_clr_wr | input | 1 | Status write; clears exceeded bit when cfg_wdata[0]=1 |
| cfg_wdata | input | 8 | Software write data |
| stat_rd | input | 1 | Status read strobe; clears exceeded bit |
| rx_vld | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| frame_sof | input | 1 | Start flag of a frame |
| frame_eof | input | 1 | End of the current frame |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| len_exceeded | output | 1 | Sticky maximum-length-exceeded status |
| frame_count | output | 13 | Bytes received in the current frame |
| limit_val | output | 13 | Programmed limit readback |

## Verification
The embedded assertions check several properties on every cycle. The count never moves by more than one step except on a start flag. A FIFO write is always caused by a byte one cycle earlier. Under a stable limit, the count after a write never exceeds that limit. The exceeded bit only rises while a nonzero limit is set, and it only falls on a clear. Nothing is written while the block is outside a frame. The bench's scenarios are the only source for the exact number of bytes that pass for each pairing of limit and frame length. They also cover resumption after the next start flag, data integrity, saturation after a very long frame, the priority of set over clear, and the silence of a clear write that has bit 0 low.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

   typedef enum logic [1:0] {
      RXG_OUT  = 2'd0,
      RXG_PASS = 2'd1,
      RXG_DROP = 2'd2
   } rxg_state_e;

   localparam int RXG_CFG_W = 8;

endpackage

// File: rtl/rxg_limit_reg.sv
module rxg_limit_reg #(
   parameter int LEN_W = 13,
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [CFG_W-1:0] wdata_i,
   output logic [LEN_W-1:0] limit_o
);

   localparam int HI_W = LEN_W - CFG_W;

   generate
      if (HI_W < 1 || HI_W > CFG_W) begin : g_bad_width
         $error("rxg_limit_reg: LEN_W must lie between CFG_W+1 and 2*CFG_W");
      end
   endgenerate

   logic [CFG_W-1:0] lo_q;
   logic [HI_W-1:0]  hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (wr_lo_i) lo_q <= wdata_i;
         if (wr_hi_i) hi_q <= wdata_i[HI_W-1:0];
      end
   end

   assign limit_o = {hi_q, lo_q};

   // R2: a high-byte write leaves the low byte untouched
   a_r2_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_lo_i)) |-> (limit_o[CFG_W-1:0] == $past(limit_o[CFG_W-1:0])));

endmodule

// File: rtl/rxg_frame_ctr.sv
module rxg_frame_ctr #(
   parameter int LEN_W    = 13,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   output logic [LEN_W-1:0] count_o
);

   localparam logic [LEN_W-1:0] ONE  = {{(LEN_W-1){1'b0}}, 1'b1};
   localparam logic [LEN_W-1:0] TOP  = '1;

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] inc;

   generate
      if (SATURATE) begin : g_sat
         assign inc = (cnt_q == TOP) ? TOP : cnt_q + ONE;
      end else begin : g_wrap
         assign inc = cnt_q + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= step_i ? ONE : '0;
      end else if (step_i) begin
         cnt_q <= inc;
      end
   end

   assign count_o = cnt_q;

   // R4: without a start flag the count holds or moves up by exactly one
   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clear_i)) |-> (count_o == $past(count_o) ||
                             count_o == $past(count_o) + ONE));

   // R3: a start flag leaves the count at zero or one
   a_r3_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear_i) |-> (count_o <= ONE));

   // R4: the saturating variant never wraps from the top value
   a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && !$past(clear_i) && $past(count_o) == TOP) |-> (count_o == TOP));

endmodule

// File: rtl/rxg_gate.sv
module rxg_gate
   import rxg_pkg::*;
#(
   parameter int LEN_W  = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_i,
   input  logic              eof_i,
   input  logic              vld_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LEN_W-1:0]  count_i,
   input  logic [LEN_W-1:0]  limit_i,
   input  logic              clr_i,
   output logic              step_o,
   output logic              clear_o,
   output logic              wr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              exceeded_o
);

   rxg_state_e       st_q, st_d;
   logic             in_frame, dropping, byte_in, over, accept, new_drop;
   logic [LEN_W-1:0] base;
   logic             wr_q, exc_q;
   logic [DATA_W-1:0] data_q;

   always_comb begin
      in_frame = sof_i || (st_q != RXG_OUT);
      dropping = !sof_i && (st_q == RXG_DROP);
      byte_in  = vld_i && in_frame;
      base     = sof_i ? '0 : count_i;
      over     = (limit_i != '0) && (base >= limit_i);
      accept   = byte_in && !dropping && !over;
      new_drop = byte_in && !dropping && over;

      st_d = st_q;
      if (eof_i && in_frame)  st_d = RXG_OUT;
      else if (new_drop)      st_d = RXG_DROP;
      else if (sof_i)         st_d = RXG_PASS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RXG_OUT;
         wr_q   <= 1'b0;
         data_q <= '0;
         exc_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         wr_q <= accept;
         if (accept) data_q <= data_i;
         if (new_drop)   exc_q <= 1'b1;
         else if (clr_i) exc_q <= 1'b0;
      end
   end

   assign step_o     = byte_in;
   assign clear_o    = sof_i;
   assign wr_o       = wr_q;
   assign data_o     = data_q;
   assign exceeded_o = exc_q;

   // R9: outside a frame nothing reaches the FIFO
   a_r9_outside_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RXG_OUT && !sof_i) |=> !wr_o);

   // R6: exceeded bit holds until a clear is requested
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (exceeded_o && !clr_i) |=> exceeded_o);

   // R8: the bit can only rise while a nonzero limit is programmed
   a_r8_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exceeded_o) |-> ($past(limit_i) != '0));

   // R5: while dropping, no later byte of the frame is written
   a_r5_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RXG_DROP && !sof_i) |=> !wr_o);

endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard
   import rxg_pkg::*;
#(
   parameter int LEN_W    = 13,
   parameter int DATA_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_lo,
   input  logic                 cfg_wr_hi,
   input  logic                 stat_clr_wr,
   input  logic [RXG_CFG_W-1:0] cfg_wdata,
   input  logic                 stat_rd,
   input  logic                 rx_vld,
   input  logic [DATA_W-1:0]    rx_data,
   input  logic                 frame_sof,
   input  logic                 frame_eof,
   output logic                 fifo_wr,
   output logic [DATA_W-1:0]    fifo_data,
   output logic                 len_exceeded,
   output logic [LEN_W-1:0]     frame_count,
   output logic [LEN_W-1:0]     limit_val
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("rx_len_guard: DATA_W must be positive");
      end
   endgenerate

   logic             clr_req, step, clear;
   logic [LEN_W-1:0] limit, count;

   assign clr_req = stat_rd || (stat_clr_wr && cfg_wdata[0]);

   rxg_limit_reg #(.LEN_W(LEN_W), .CFG_W(RXG_CFG_W)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo_i (cfg_wr_lo),
      .wr_hi_i (cfg_wr_hi),
      .wdata_i (cfg_wdata),
      .limit_o (limit)
   );

   rxg_frame_ctr #(.LEN_W(LEN_W), .SATURATE(SATURATE)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .step_i  (step),
      .count_o (count)
   );

   rxg_gate #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_i      (frame_sof),
      .eof_i      (frame_eof),
      .vld_i      (rx_vld),
      .data_i     (rx_data),
      .count_i    (count),
      .limit_i    (limit),
      .clr_i      (clr_req),
      .step_o     (step),
      .clear_o    (clear),
      .wr_o       (fifo_wr),
      .data_o     (fifo_data),
      .exceeded_o (len_exceeded)
   );

   assign frame_count = count;
   assign limit_val   = limit;

   // R5: every FIFO write is caused by a byte one cycle earlier
   a_r5_write_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(rx_vld));

   // R5: with a stable nonzero limit the frame never writes past it
   a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && limit_val != '0 && $stable(limit_val)) |-> (frame_count <= limit_val));

endmodule

// File: tb/rx_len_guard_tb.sv
module rx_len_guard_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_lo = 0, cfg_wr_hi = 0, stat_clr_wr = 0, stat_rd = 0;
   logic [7:0]  cfg_wdata = '0;
   logic        rx_vld = 0, frame_sof = 0, frame_eof = 0;
   logic [7:0]  rx_data = '0;
   logic        fifo_wr, len_exceeded;
   logic [7:0]  fifo_data;
   logic [12:0] frame_count, limit_val;

   int checks = 0;
   int errors = 0;
   int wr_seen = 0;

   always #5 clk = ~clk;

   rx_len_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi),
      .stat_clr_wr(stat_clr_wr), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
      .rx_vld(rx_vld), .rx_data(rx_data), .frame_sof(frame_sof), .frame_eof(frame_eof),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .len_exceeded(len_exceeded),
      .frame_count(frame_count), .limit_val(limit_val)
   );

   function automatic logic [7:0] pat(int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drives one cycle of inputs at the falling edge
   task automatic drive(logic s, logic e, logic v, logic [7:0] d,
                        logic wlo, logic whi, logic cw, logic rd, logic [7:0] wd);
      @(negedge clk);
      frame_sof = s; frame_eof = e; rx_vld = v; rx_data = d;
      cfg_wr_lo = wlo; cfg_wr_hi = whi; stat_clr_wr = cw; stat_rd = rd; cfg_wdata = wd;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
   endtask

   task automatic set_limit(int lim);
      drive(0, 0, 0, 8'h00, 1, 0, 0, 0, 8'(lim & 255));
      drive(0, 0, 0, 8'h00, 0, 1, 0, 0, 8'((lim >> 8) & 255));
      idle(1);
   endtask

   task automatic send_frame(int n);
      wr_seen = 0;
      drive(1, 0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
      if (n == 0) drive(0, 1, 0, 8'h00, 0, 0, 0, 0, 8'h00);
      for (int i = 0; i < n; i++) drive(0, i == n - 1, 1, pat(i), 0, 0, 0, 0, 8'h00);
      idle(2);
   endtask

   // FIFO monitor: data must follow the frame's byte pattern (R5)
   always @(negedge clk) begin
      if (rst_n && fifo_wr) begin
         chk(fifo_data == pat(wr_seen), "R5 data", int'(fifo_data), int'(pat(wr_seen)));
         wr_seen++;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(limit_val == 0, "R1 limit", int'(limit_val), 0);
      chk(frame_count == 0, "R1 count", int'(frame_count), 0);
      chk(len_exceeded == 0, "R1 exceeded", int'(len_exceeded), 0);
      chk(fifo_wr == 0, "R1 fifo_wr", int'(fifo_wr), 0);

      // R9: bytes before any start flag are ignored
      wr_seen = 0;
      drive(0, 0, 1, 8'h11, 0, 0, 0, 0, 8'h00);
      drive(0, 0, 1, 8'h22, 0, 0, 0, 0, 8'h00);
      idle(2);
      chk(frame_count == 0, "R9 count pre-sof", int'(frame_count), 0);
      chk(wr_seen == 0, "R9 writes pre-sof", wr_seen, 0);

      // R2 limit register fields
      set_limit(13'h1ABC);
      chk(limit_val == 13'h1ABC, "R2 limit load", int'(limit_val), 'h1ABC);
      drive(0, 0, 0, 8'h00, 0, 1, 0, 0, 8'hFF);
      idle(1);
      chk(limit_val == 13'h1FBC, "R2 high bits only", int'(limit_val), 'h1FBC);

      // sweep limit x frame length (R4 R5 R6 R8 R10 R7)
      for (int lim = 0; lim <= 6; lim++) begin
         set_limit(lim);
         for (int n = 0; n <= 8; n++) begin
            int exp_w;
            bit exp_x;
            exp_w = (lim == 0 || n <= lim) ? n : lim;
            exp_x = (lim != 0 && n > lim);
            send_frame(n);
            chk(frame_count == 13'(n), "R4 R10 count", int'(frame_count), n);
            chk(wr_seen == exp_w, "R5 R8 writes", wr_seen, exp_w);
            chk(len_exceeded == exp_x, "R6 R8 exceeded", int'(len_exceeded), int'(exp_x));
            if (exp_x) begin
               // R7 clear write with bit0 low must not clear
               drive(0, 0, 0, 8'h00, 0, 0, 1, 0, 8'hFE);
               idle(1);
               chk(len_exceeded == 1, "R7 bit0 low", int'(len_exceeded), 1);
               if (n % 2 == 0) drive(0, 0, 0, 8'h00, 0, 0, 0, 1, 8'h00);
               else            drive(0, 0, 0, 8'h00, 0, 0, 1, 0, 8'h01);
               idle(1);
               chk(len_exceeded == 0, "R7 clear", int'(len_exceeded), 0);
            end
            // R9: bytes after end of frame are ignored
            if (n == 3) begin
               wr_seen = 0;
               drive(0, 0, 1, 8'h33, 0, 0, 0, 0, 8'h00);
               drive(0, 0, 1, 8'h44, 0, 0, 0, 0, 8'h00);
               idle(2);
               chk(frame_count == 3, "R9 count post-eof", int'(frame_count), 3);
               chk(wr_seen == 0, "R9 writes post-eof", wr_seen, 0);
            end
         end
      end

      // R3: start flag together with first byte
      set_limit(0);
      wr_seen = 0;
      drive(1, 0, 1, pat(0), 0, 0, 0, 0, 8'h00);
      drive(0, 0, 1, pat(1), 0, 0, 0, 0, 8'h00);
      drive(0, 1, 1, pat(2), 0, 0, 0, 0, 8'h00);
      idle(2);
      chk(frame_count == 3, "R3 sof with byte", int'(frame_count), 3);
      chk(wr_seen == 3, "R3 writes", wr_seen, 3);

      // R7: overrun in the same cycle as a clear keeps the bit set
      set_limit(1);
      wr_seen = 0;
      drive(1, 0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
      drive(0, 0, 1, pat(0), 0, 0, 0, 0, 8'h00);
      drive(0, 1, 1, pat(1), 0, 0, 0, 1, 8'h00);
      idle(2);
      chk(len_exceeded == 1, "R7 set wins", int'(len_exceeded), 1);
      chk(wr_seen == 1, "R5 limit one", wr_seen, 1);
      drive(0, 0, 0, 8'h00, 0, 0, 0, 1, 8'h00);
      idle(1);
      chk(len_exceeded == 0, "R7 read clear", int'(len_exceeded), 0);

      // R4 saturation over a very long frame, no limit
      set_limit(0);
      wr_seen = 0;
      drive(1, 0, 0, 8'h00, 0, 0, 0, 0, 8'h00);
      for (int i = 0; i < 8200; i++) drive(0, i == 8199, 1, pat(i), 0, 0, 0, 0, 8'h00);
      idle(2);
      chk(frame_count == 13'd8191, "R4 saturate", int'(frame_count), 8191);
      chk(wr_seen == 8200, "R8 long frame writes", wr_seen, 8200);
      chk(len_exceeded == 0, "R8 no flag", int'(len_exceeded), 0);

      // R3: next start flag clears the count
      send_frame(0);
      chk(frame_count == 0, "R3 clear", int'(frame_count), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule